// File: doc/BRIEF.md
# Registered Unsigned Array Multiplier

This block multiplies two unsigned operands with a regular grid of AND gates and full-adder cells. No behavioural multiply operator is used. Row zero of the grid is the multiplicand gated by multiplier bit 0. Each later row gates the multiplicand with the next multiplier bit. It then adds that gated word to the running sum handed down from the row above, which is shifted one place right. Carries ripple along each row. Every row retires one low product bit, and the last row supplies the upper half of the product.

Both operands are captured in input registers, and the product is captured in an output register. All of these registers clear on an active-low asynchronous reset. A small control unit holds off the product register on the first edge after reset, so that no product is loaded before any operands have been captured. The default build is 8 by 8 bits with a 16-bit product.

Top module: `array_mult_reg`

## Requirements
- R1: While the reset input is low, and on the first rising edge after it goes high, the product output is 0.
- R2: Operands that are present at rising edge k are captured there. Their unsigned product appears on the output after rising edge k+1 and holds until the next edge.
- R3: Bit 0 of the product equals operand-A bit 0 ANDed with operand-B bit 0 of the captured pair.
- R4: When either captured operand is zero, the product is zero.
- R5: The product is NA+NB bits wide and is never truncated. For the default build, 255 times 255 gives 65025.
- R6: 12 times 11 gives 132.
- R7: A new operand pair may be presented on every clock. The products then follow one per clock, in the same order as the pairs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| opA | input | NA | Multiplicand, unsigned |
| opB | input | NB | Multiplier, unsigned |
| product | output | NA+NB | Registered product, unsigned |

## Verification
Each product is due exactly two rising edges after its operands are driven. The first edge captures the operands and the second loads the product register. The bench drives its inputs on a falling edge and then waits two falling edges before it reads the output, so that each read falls midway between edges. In the streaming test, the bench sends a new pair every clock and compares each output with the expected value for the pair sent two clocks earlier. The reset test reads the output both while the reset is held and just after the first edge that follows its release.

// File: rtl/amul_pkg.sv
package amul_pkg;
  typedef struct packed {
    logic loadOperands;
    logic loadProduct;
  } amulCtrl_t;
endpackage

// File: rtl/amul_cell.sv
module amul_cell (
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co
);
  assign s  = a ^ b ^ ci;
  assign co = (a & b) | (ci & (a ^ b));
endmodule

// File: rtl/amul_array.sv
module amul_array #(
  parameter int NA = 8,
  parameter int NB = 8,
  localparam int PW = NA + NB
) (
  input  logic [NA-1:0] mcand,
  input  logic [NB-1:0] mplier,
  output logic [PW-1:0] prod
);
  logic [NB-1:0] lowBits;

  for (genvar i = 0; i < NB; i++) begin : rowGen
    logic [NA-1:0] partial;
    logic [NA-1:0] sumBits;
    logic          coutBit;
    assign partial = mcand & {NA{mplier[i]}};

    if (i == 0) begin : firstRow
      assign sumBits = partial;
      assign coutBit = 1'b0;
    end else begin : addRow
      logic [NA-1:0] upper;
      logic [NA:0]   carry;
      assign upper    = {rowGen[i-1].coutBit, rowGen[i-1].sumBits[NA-1:1]};
      assign carry[0] = 1'b0;
      for (genvar j = 0; j < NA; j++) begin : cellGen
        amul_cell u_cell (
          .a (partial[j]),
          .b (upper[j]),
          .ci(carry[j]),
          .s (sumBits[j]),
          .co(carry[j+1])
        );
      end
      assign coutBit = carry[NA];
    end

    assign lowBits[i] = sumBits[0];
  end

  assign prod = {rowGen[NB-1].coutBit, rowGen[NB-1].sumBits[NA-1:1], lowBits};
endmodule

// File: rtl/amul_ctrl.sv
module amul_ctrl
  import amul_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  output amulCtrl_t ctrl
);
  logic primed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) primed <= 1'b0;
    else       primed <= 1'b1;
  end

  always_comb begin
    ctrl.loadOperands = rstN;
    ctrl.loadProduct  = primed;
  end
endmodule

// File: rtl/amul_datapath.sv
module amul_datapath
  import amul_pkg::*;
#(
  parameter int NA = 8,
  parameter int NB = 8,
  localparam int PW = NA + NB
) (
  input  logic          clk,
  input  logic          rstN,
  input  amulCtrl_t     ctrl,
  input  logic [NA-1:0] opA,
  input  logic [NB-1:0] opB,
  output logic [PW-1:0] product
);
  logic [NA-1:0] regA;
  logic [NB-1:0] regB;
  logic [PW-1:0] arrayOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regA <= '0;
      regB <= '0;
    end else if (ctrl.loadOperands) begin
      regA <= opA;
      regB <= opB;
    end
  end

  amul_array #(.NA(NA), .NB(NB)) u_array (
    .mcand (regA),
    .mplier(regB),
    .prod  (arrayOut)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 product <= '0;
    else if (ctrl.loadProduct) product <= arrayOut;
  end
endmodule

// File: rtl/array_mult_reg.sv
module array_mult_reg
  import amul_pkg::*;
#(
  parameter int NA = 8,
  parameter int NB = 8,
  localparam int PW = NA + NB
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [NA-1:0] opA,
  input  logic [NB-1:0] opB,
  output logic [PW-1:0] product
);
  amulCtrl_t ctrl;

  amul_ctrl u_ctrl (
    .clk (clk),
    .rstN(rstN),
    .ctrl(ctrl)
  );

  amul_datapath #(.NA(NA), .NB(NB)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctrl   (ctrl),
    .opA    (opA),
    .opB    (opB),
    .product(product)
  );
endmodule

// File: rtl/amul_checker.sv
module amul_checker #(
  parameter int NA = 8,
  parameter int NB = 8,
  localparam int PW = NA + NB
) (
  input logic          clk,
  input logic          rstN,
  input logic [NA-1:0] opA,
  input logic [NB-1:0] opB,
  input logic [PW-1:0] product
);
  logic [1:0] cyc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         cyc <= '0;
    else if (cyc != 2) cyc <= cyc + 2'd1;
  end

  // R1: the output stays clear while reset is held
  always @(posedge clk) begin
    if (!rstN) assert_reset_clear_R1: assert (product == '0);
  end

  // R1: the output is still clear after the first edge out of reset
  assert_first_edge_R1: assert property (@(posedge clk) disable iff (!rstN)
    (cyc == 2'd1) |-> (product == '0));

  // R2: the product matches the pair presented two edges earlier
  assert_product_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cyc == 2'd2) |-> (product == (PW'($past(opA, 2)) * PW'($past(opB, 2)))));

  // R3: the low product bit
  assert_lsb_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cyc == 2'd2) |-> (product[0] == ($past(opA[0], 2) & $past(opB[0], 2))));

  // R4: a zero operand gives a zero product
  assert_zero_operand_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((cyc == 2'd2) && (($past(opA, 2) == '0) || ($past(opB, 2) == '0))) |-> (product == '0));
endmodule

bind array_mult_reg amul_checker #(.NA(NA), .NB(NB)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .opA    (opA),
  .opB    (opB),
  .product(product)
);

// File: tb/array_mult_reg_bench.sv
module array_mult_reg_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NA = 8;
  localparam int NB = 8;
  localparam int PW = NA + NB;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NA-1:0] opA = '0;
  logic [NB-1:0] opB = '0;
  logic [PW-1:0] product;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  array_mult_reg #(.NA(NA), .NB(NB)) u_array_mult_reg (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .product(product)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run did not finish, actual %0d cycles, expected fewer", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic check(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive on a falling edge, read two falling edges later
  task automatic apply(input string req, input int a, input int b);
    opA = NA'(a);
    opB = NB'(b);
    repeat (2) @(negedge clk);
    check(req, product, PW'(a) * PW'(b));
  endtask

  task automatic test_reset_r1();
    opA = 8'd200;
    opB = 8'd150;
    repeat (3) @(negedge clk);
    check("R1 during reset", product, '0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 first edge after reset", product, '0);
    @(negedge clk);
    check("R2 first product after reset", product, 16'd30000);
  endtask

  task automatic test_worked_r6();
    apply("R6 12x11", 12, 11);
    check("R6 value 132", product, 16'd132);
  endtask

  task automatic test_max_r5();
    apply("R5 255x255", 255, 255);
    check("R5 value 65025", product, 16'd65025);
    apply("R5 255x1", 255, 1);
    apply("R5 128x128", 128, 128);
  endtask

  task automatic test_zero_r4();
    apply("R4 0xff", 0, 255);
    apply("R4 ffx0", 255, 0);
    apply("R4 0x0", 0, 0);
  endtask

  task automatic test_lsb_r3();
    apply("R3 odd x odd", 1, 1);
    check("R3 bit0 set", PW'(product[0]), 1);
    apply("R3 odd x even", 173, 2);
    check("R3 bit0 clear", PW'(product[0]), 0);
  endtask

  task automatic test_patterns_r2();
    apply("R2 0xaa x 0x55", 8'haa, 8'h55);
    apply("R2 0x0f x 0xf0", 8'h0f, 8'hf0);
    apply("R2 walking 0x80 x 0x03", 8'h80, 8'h03);
    for (int k = 0; k < 12; k++) begin
      apply("R2 sweep", (k * 37 + 5) & 255, (k * 91 + 13) & 255);
    end
  endtask

  task automatic test_stream_r7();
    logic [PW-1:0] expQ[0:39];
    for (int t = 0; t < 40; t++) begin
      int a = (t * 53 + 7) & 255;
      int b = (t * 29 + 200) & 255;
      expQ[t] = PW'(a) * PW'(b);
      opA = NA'(a);
      opB = NB'(b);
      @(negedge clk);
      if (t >= 1) check("R7 stream", product, expQ[t-1]);
    end
    @(negedge clk);
    check("R7 stream tail", product, expQ[39]);
  endtask

  initial begin
    test_reset_r1();
    test_worked_r6();
    test_max_r5();
    test_zero_r4();
    test_lsb_r3();
    test_patterns_r2();
    test_stream_r7();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule